// File: doc/BRIEF.md
# Two-Entry Delayed-Write Buffer with Read Forwarding

This block sits in front of a single internal SRAM array and delays every write by two write operations. The two most recent writes are held as entries of data, address tag and access-width flag. When a new write arrives, the older held entry is written into the array in that same cycle, the newer entry becomes the older one, and the incoming write becomes the newest entry. A read whose address and width match a held entry is answered from the buffer. Any other read returns the array word.

Software-visible aliasing follows from the width flag. A wide (48-bit) write followed by a narrow (32-bit) read of the same location is not forwarded, so the read sees the array contents from before that write. To push both pending entries into the array, a caller issues two consecutive dummy writes. A dummy write commits the older entry and queues an empty slot.

Top module: `shadow_wbuf`

## Requirements
- R1: After reset both entries are invalid. An invalid entry never drives a commit (`arr_we` stays low for the first two real writes after reset), and it never answers a read. `rd_valid` is low after reset.
- R2: A write (`req_wr`=1) while the older entry is valid raises `arr_we` in that same cycle. At that clock edge the older entry's data is written into the array.
- R3: The commit carries the address, data and width flag of the write issued two writes earlier. The incoming write becomes the newest entry, and the previous newest entry becomes the older one.
- R4: A read whose address and width flag match exactly one valid entry returns that entry's data.
- R5: When both valid entries match the read address and width, the newest entry's data is returned.
- R6: The width flag (`req_wide`: 1 = 48-bit access, 0 = 32-bit access) is part of the match. A read whose address equals a held tag but whose width differs returns the array word, not the buffered data.
- R7: `rd_valid` is high exactly in the cycle after `req_rd`. When no entry matches, `rd_data` in that cycle is the array word at the read address.
- R8: A dummy write (`req_wr`=1 with `req_dummy`=1) commits the older entry if it is valid and queues an invalid entry. Two consecutive dummy writes leave both pending entries in the array.
- R9: A read issued in the same cycle as a write sees the buffer and array as they were before that write. This includes the entry being committed in that cycle.
- R10: In a cycle without `req_wr`, `arr_we` is low and the held entries do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Write data |
| req_wr | input | 1 | Write request |
| req_dummy | input | 1 | With req_wr: dummy write that queues an empty slot |
| req_rd | input | 1 | Read request |
| req_wide | input | 1 | Access width: 1 = 48-bit, 0 = 32-bit |
| rd_valid | output | 1 | Read data valid, one cycle after req_rd |
| rd_data | output | DW | Read data |
| arr_we | output | 1 | Array-side commit strobe |
| arr_addr | output | AW | Address of the committed entry |
| arr_wdata | output | DW | Data of the committed entry |
| arr_wide | output | 1 | Width flag of the committed entry |

## Verification
The bench builds the block with AW=4 and DW=48. A 16-word array makes random addresses collide with the held tags on a large fraction of reads, so forwarding from either entry, newest-wins overlap, width-mismatched aliasing and read-during-commit all occur many times. The full 48-bit data width keeps the array word and the buffered word distinguishable, so a forwarding error shows up in `rd_data`. The default AW=10 is only elaborated.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int NUM_ENT = 2;
  typedef enum logic {
    ACC_NARROW = 1'b0,
    ACC_WIDE   = 1'b1
  } acc_width_e;
endpackage

// File: rtl/swb_ram.sv
module swb_ram #(
  parameter int AW = 10,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first block RAM: a read to the address being written returns old data
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/swb_entries.sv
module swb_entries
  import swb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 48
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       dummy,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       wide,
  output logic [NUM_ENT-1:0]         ent_v,
  output logic [NUM_ENT-1:0]         ent_w,
  output logic [NUM_ENT-1:0][AW-1:0] ent_a,
  output logic [NUM_ENT-1:0][DW-1:0] ent_d,
  output logic                       cm_we,
  output logic [AW-1:0]              cm_addr,
  output logic [DW-1:0]              cm_data,
  output logic                       cm_wide
);
  localparam int OLD = NUM_ENT - 1;

  // slot 0 is the newest entry, slot OLD the oldest
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      ent_w <= '0;
      ent_a <= '0;
      ent_d <= '0;
    end else if (wr) begin
      ent_v[0] <= ~dummy;
      ent_w[0] <= wide;
      ent_a[0] <= addr;
      ent_d[0] <= wdata;
      for (int i = 1; i < NUM_ENT; i++) begin
        ent_v[i] <= ent_v[i-1];
        ent_w[i] <= ent_w[i-1];
        ent_a[i] <= ent_a[i-1];
        ent_d[i] <= ent_d[i-1];
      end
    end
  end

  assign cm_we   = wr & ent_v[OLD];
  assign cm_addr = ent_a[OLD];
  assign cm_data = ent_d[OLD];
  assign cm_wide = ent_w[OLD];

  p_reset_empty_r1: assert property (@(posedge clk) rst |=> (ent_v == '0));
  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ent_v[1] == $past(ent_v[0]) && ent_a[1] == $past(ent_a[0])
            && ent_d[1] == $past(ent_d[0]) && ent_w[1] == $past(ent_w[0])));
  p_dummy_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && dummy) |=> !ent_v[0]);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(ent_v) && $stable(ent_a) && $stable(ent_d) && $stable(ent_w)));
endmodule

// File: rtl/swb_fwd.sv
module swb_fwd
  import swb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 48
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_ENT-1:0]         ent_v,
  input  logic [NUM_ENT-1:0]         ent_w,
  input  logic [NUM_ENT-1:0][AW-1:0] ent_a,
  input  logic [NUM_ENT-1:0][DW-1:0] ent_d,
  input  logic [AW-1:0]              raddr,
  input  logic                       rwide,
  output logic                       hit,
  output logic [DW-1:0]              hdata
);
  logic [NUM_ENT-1:0] match;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_a[g] == raddr) && (ent_w[g] == rwide);
  end

  // scan oldest to newest so the newest matching slot is assigned last
  always_comb begin
    hit   = 1'b0;
    hdata = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        hdata = ent_d[i];
      end
    end
  end

  p_newest_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (ent_v[0] && ent_a[0] == raddr && ent_w[0] == rwide) |-> (hdata == ent_d[0]));
  p_no_invalid_hit_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (ent_v != '0));
endmodule

// File: rtl/shadow_wbuf.sv
module shadow_wbuf
  import swb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wr,
  input  logic          req_dummy,
  input  logic          req_rd,
  input  logic          req_wide,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_wide
);
  logic [NUM_ENT-1:0]         ent_v, ent_w;
  logic [NUM_ENT-1:0][AW-1:0] ent_a;
  logic [NUM_ENT-1:0][DW-1:0] ent_d;
  logic                       hit;
  logic [DW-1:0]              hdata;
  logic [DW-1:0]              ram_q;
  logic                       fwd_hit_q;
  logic [DW-1:0]              fwd_data_q;

  swb_entries #(.AW(AW), .DW(DW)) u_ent (
    .clk(clk), .rst(rst), .wr(req_wr), .dummy(req_dummy), .addr(req_addr),
    .wdata(req_wdata), .wide(req_wide), .ent_v(ent_v), .ent_w(ent_w),
    .ent_a(ent_a), .ent_d(ent_d), .cm_we(arr_we), .cm_addr(arr_addr),
    .cm_data(arr_wdata), .cm_wide(arr_wide)
  );

  swb_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .clk(clk), .rst(rst), .ent_v(ent_v), .ent_w(ent_w), .ent_a(ent_a),
    .ent_d(ent_d), .raddr(req_addr), .rwide(req_wide), .hit(hit), .hdata(hdata)
  );

  swb_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .raddr(req_addr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      fwd_hit_q  <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      rd_valid   <= req_rd;
      fwd_hit_q  <= req_rd & hit;
      fwd_data_q <= hdata;
    end
  end

  assign rd_data = fwd_hit_q ? fwd_data_q : ram_q;

  p_rd_latency_r7: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rd_valid);
  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> !rd_valid);
  p_commit_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> req_wr);
endmodule

// File: tb/shadow_wbuf_test.sv
`timescale 1ns/1ps
module shadow_wbuf_test;
  localparam int AW = 4;
  localparam int DW = 48;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_wr = 1'b0, req_dummy = 1'b0, req_rd = 1'b0, req_wide = 1'b0;
  logic          rd_valid, arr_we, arr_wide;
  logic [DW-1:0] rd_data, arr_wdata;
  logic [AW-1:0] arr_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mem_m [DEPTH];
  bit            mv [2];
  bit            mw [2];
  logic [AW-1:0] ma [2];
  logic [DW-1:0] md [2];

  always #2.5 clk = ~clk;

  shadow_wbuf #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wr(req_wr), .req_dummy(req_dummy), .req_rd(req_rd), .req_wide(req_wide),
    .rd_valid(rd_valid), .rd_data(rd_data), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_wide(arr_wide)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd48();
    return {16'($urandom()), $urandom()};
  endfunction

  task automatic step(input bit wr, input bit dm, input bit rd, input logic [AW-1:0] ad,
                      input logic [DW-1:0] dt, input bit wd);
    bit exp_we, h0, h1, alias_hit;
    logic [DW-1:0] exp_rd;
    string wtag, rtag;
    @(negedge clk);
    req_wr = wr; req_dummy = dm; req_rd = rd; req_addr = ad; req_wdata = dt; req_wide = wd;
    #1;
    exp_we = wr && mv[1];
    wtag = !wr ? "R10 no commit without write" : dm ? "R8 dummy write commit" :
           mv[1] ? "R2 commit strobe" : "R1 invalid entry commits nothing";
    chk(arr_we === exp_we, wtag, DW'(arr_we), DW'(exp_we));
    if (exp_we) begin
      chk(arr_addr === ma[1], "R3 committed address", DW'(arr_addr), DW'(ma[1]));
      chk(arr_wdata === md[1], "R3 committed data", arr_wdata, md[1]);
      chk(arr_wide === mw[1], "R3 committed width", DW'(arr_wide), DW'(mw[1]));
    end
    h0 = mv[0] && ma[0] == ad && mw[0] == wd;
    h1 = mv[1] && ma[1] == ad && mw[1] == wd;
    alias_hit = (mv[0] && ma[0] == ad) || (mv[1] && ma[1] == ad);
    exp_rd = h0 ? md[0] : h1 ? md[1] : mem_m[ad];
    rtag = wr ? "R9 read beside write" : (h0 && h1) ? "R5 newest wins" :
           (h0 || h1) ? "R4 forwarded read" : alias_hit ? "R6 width mismatch to array" :
           "R7 array read";
    if (exp_we) mem_m[ma[1]] = md[1];
    if (wr) begin
      mv[1] = mv[0]; mw[1] = mw[0]; ma[1] = ma[0]; md[1] = md[0];
      mv[0] = !dm;   mw[0] = wd;    ma[0] = ad;    md[0] = dt;
    end
    @(posedge clk);
    #1;
    chk(rd_valid === rd, "R7 read valid timing", DW'(rd_valid), DW'(rd));
    if (rd) chk(rd_data === exp_rd, rtag, rd_data, exp_rd);
    req_wr = 0; req_rd = 0; req_dummy = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL all: watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [DW-1:0] d1, d2;
    seed = int'($urandom(32'd2024));
    mv[0] = 0; mv[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk(rd_valid === 1'b0, "R1 rd_valid low after reset", DW'(rd_valid), '0);
    chk(arr_we === 1'b0, "R1 no commit after reset", DW'(arr_we), '0);

    // fill every word, then flush both entries with two dummy writes
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, AW'(i), rnd48(), 1);
    step(1, 1, 0, '0, '0, 1);
    step(1, 1, 0, '0, '0, 1);

    // R5: two writes to one address, both held
    d1 = rnd48(); d2 = rnd48();
    step(1, 0, 0, 4'd5, d1, 1);
    step(1, 0, 0, 4'd5, d2, 1);
    step(0, 0, 1, 4'd5, '0, 1);
    // R6: narrow read of a wide-written location falls through
    step(0, 0, 1, 4'd5, '0, 0);
    // R4: the older entry answers
    step(1, 0, 0, 4'd7, rnd48(), 0);
    step(0, 0, 1, 4'd5, '0, 1);
    // R8: two dummy writes flush, then reads come from the array
    step(1, 1, 0, '0, '0, 0);
    step(1, 1, 0, '0, '0, 0);
    step(0, 0, 1, 4'd7, '0, 0);
    step(0, 0, 1, 4'd5, '0, 1);
    // R10: idle cycle
    step(0, 0, 0, 4'd3, rnd48(), 1);
    // R9: read and write of one address in the same cycle
    step(1, 0, 1, 4'd9, rnd48(), 1);
    step(1, 0, 1, 4'd9, rnd48(), 1);
    step(1, 0, 1, 4'd9, rnd48(), 1);

    for (int n = 0; n < 600; n++) begin
      bit w, dm, r, wd;
      w  = ($urandom() % 10) < 6;
      dm = w && (($urandom() % 10) == 0);
      r  = ($urandom() % 10) < 6;
      wd = $urandom() % 2;
      step(w, dm, r, AW'($urandom()), rnd48(), wd);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule